// File: doc/BRIEF.md
# 4x4 Diagonal-Down-Left Intra Predictor

This block produces the sixteen predicted luma samples of one 4x4 sub-block along the down-left diagonal direction (mode 3 of the 4x4 luma intra modes). A neighbour set is handed in through a valid/ready handshake. It carries the eight reconstructed samples above and above-right of the sub-block (named A to H from left to right), a flag saying whether the four above-right samples E to H exist, and a flag marking the first sub-block of a macroblock. The block then streams the prediction out one column of four samples per clock.

On acceptance the block registers the eight pairwise neighbour sums once. Every output column is then read from those sums. Samples on the same anti-diagonal (equal row + column) share one value, so only seven distinct predictions exist.

Back-pressure rules: `nb_ready` is high only while the block is idle. A neighbour set is taken on a clock edge where `nb_valid` and `nb_ready` are both high. `nb_valid` has no effect while `nb_ready` is low. On the output side, `halt` is the stall. At an edge where `halt` is high, no column is issued, the column counter and the output data hold, and `col_valid` is low in the following cycle. The consumer takes a column in every cycle where `col_valid` is high.

Top module: `ddl4x4_pred`

## Requirements
- R1: After reset, `col_valid` is 0, `col_data` is 0 and `nb_ready` is 1.
- R2: A neighbour set is accepted only at an edge with `nb_valid` and `nb_ready` both high. `nb_ready` is 0 from the cycle after acceptance until the last column is issued. While it is 0, changes on `nb_valid`, `nb_top`, `ur_avail` and `first_blk` do not alter the columns produced.
- R3: With neighbours N[0..7] = A..H, `nb_top[8k+7:8k]` = N[k], the sample at row i, column j is (N[k] + 2*N[k+1] + N[k+2] + 2) >> 2 with k = i + j, for k from 0 to 5.
- R4: The bottom-right sample (k = 6) is (G + 3*H + 2) >> 2.
- R5: All samples with equal i + j are equal. In particular, row i of column j+1 equals row i+1 of column j.
- R6: When `ur_avail` is 0, E, F, G and H each take the value of D, whatever `nb_top[63:32]` holds.
- R7: When `first_blk` is 1 at acceptance, all sixteen predicted samples are 0, whatever the neighbours.
- R8: After acceptance, exactly four cycles with `col_valid` high follow, with `col_idx` equal to 0, 1, 2 and 3 in that order. Without halt, the first valid cycle is the second cycle after the accepting edge.
- R9: An edge with `halt` high issues no column. In the next cycle `col_valid` is 0 and `col_data` and `col_idx` keep their values, and the stream resumes at the held column.
- R10: In the cycle that shows column 3, `nb_ready` is back at 1. No further valid column appears until a new set is accepted.
- R11: `col_data[8i+7:8i]` carries row i of the column shown, with row 0 in the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| nb_valid | input | 1 | Neighbour set offered |
| nb_ready | output | 1 | Block idle, neighbour set can be taken |
| nb_top | input | 64 | Neighbours A..H, A in bits 7:0 |
| ur_avail | input | 1 | Above-right samples E..H exist |
| first_blk | input | 1 | First sub-block of macroblock, predict all zero |
| halt | input | 1 | Stall: hold counter and output |
| col_valid | output | 1 | A predicted column is shown |
| col_idx | output | 2 | Column number of the shown data |
| col_data | output | 32 | Four predicted samples, row 0 in bits 7:0 |

## Verification
Two events can fall in the same cycle. The block can return to ready while its final column is still on the output, and a stall can arrive just as a column would be issued. The bench asserts `halt` at various points inside a stream, including the edge that would issue column 0 and the edge that would issue column 3. It checks that the column number neither skips nor repeats, and that the held data matches the previous cycle. It also offers a new neighbour set with different data while the block is busy, and checks that the column then being produced is unchanged and that `nb_ready` is high exactly when column 3 appears.

// File: rtl/ddl_pkg.sv
package ddl_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;
endpackage

// File: rtl/ddl_pair_sums.sv
module ddl_pair_sums #(
  parameter int SW  = 8,
  parameter int BLK = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [2*BLK*SW-1:0]    nb_flat,
  input  logic                   ur_avail,
  input  logic                   first_blk,
  output logic [2*BLK*(SW+1)-1:0] pairs_flat
);
  localparam int NN = 2 * BLK;
  localparam int PW = SW + 1;

  logic [SW-1:0] nb_eff [NN];
  logic [PW-1:0] pair_d [NN];

  // upper-right samples fall back to the last top sample when absent
  for (genvar g = 0; g < NN; g++) begin : g_pad
    if (g < BLK) begin : g_top
      assign nb_eff[g] = nb_flat[g*SW +: SW];
    end else begin : g_ur
      assign nb_eff[g] = ur_avail ? nb_flat[g*SW +: SW] : nb_flat[(BLK-1)*SW +: SW];
    end
  end

  for (genvar g = 0; g < NN; g++) begin : g_pair
    if (g < NN - 1) begin : g_mid
      assign pair_d[g] = first_blk ? '0 : ({1'b0, nb_eff[g]} + {1'b0, nb_eff[g+1]});
    end else begin : g_end
      assign pair_d[g] = first_blk ? '0 : {nb_eff[g], 1'b0};
    end
    always_ff @(posedge clk) begin
      if (!rst_n)    pairs_flat[g*PW +: PW] <= '0;
      else if (load) pairs_flat[g*PW +: PW] <= pair_d[g];
    end
  end
endmodule

// File: rtl/ddl_col_gen.sv
module ddl_col_gen #(
  parameter int SW  = 8,
  parameter int BLK = 4,
  localparam int CW = $clog2(BLK)
) (
  input  logic [2*BLK*(SW+1)-1:0] pairs_flat,
  input  logic [CW-1:0]           col,
  output logic [BLK*SW-1:0]       col_pix
);
  localparam int PW = SW + 1;
  localparam int TW = SW + 2;

  logic [PW-1:0] pr [2*BLK];

  for (genvar g = 0; g < 2*BLK; g++) begin : g_unpack
    assign pr[g] = pairs_flat[g*PW +: PW];
  end

  for (genvar r = 0; r < BLK; r++) begin : g_row
    logic [TW-1:0] tot;
    always_comb begin
      int k;
      k = r + int'(col);
      tot = {1'b0, pr[k]} + {1'b0, pr[k+1]} + TW'(2);
    end
    assign col_pix[r*SW +: SW] = tot[TW-1:2];
  end
endmodule

// File: rtl/ddl_seq.sv
module ddl_seq #(
  parameter int BLK = 4,
  localparam int CW = $clog2(BLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          halt,
  output logic          busy,
  output logic          issue,
  output logic [CW-1:0] col
);
  import ddl_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(BLK - 1);

  seq_state_e st_q;

  assign busy  = (st_q == ST_RUN);
  assign issue = busy && !halt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      col  <= '0;
    end else if (start) begin
      st_q <= ST_RUN;
      col  <= '0;
    end else if (issue) begin
      if (col == LAST) st_q <= ST_IDLE;
      col <= col + 1'b1;
    end
  end
endmodule

// File: rtl/ddl4x4_pred.sv
module ddl4x4_pred #(
  parameter int SW  = 8,
  parameter int BLK = 4,
  localparam int CW = $clog2(BLK)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                nb_valid,
  output logic                nb_ready,
  input  logic [2*BLK*SW-1:0] nb_top,
  input  logic                ur_avail,
  input  logic                first_blk,
  input  logic                halt,
  output logic                col_valid,
  output logic [CW-1:0]       col_idx,
  output logic [BLK*SW-1:0]   col_data
);
  localparam int PW = SW + 1;

  logic                    busy, issue, accept;
  logic [CW-1:0]           col;
  logic [2*BLK*PW-1:0]     pairs;
  logic [BLK*SW-1:0]       col_pix;

  assign nb_ready = !busy;
  assign accept   = nb_valid && nb_ready;

  ddl_seq #(.BLK(BLK)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .halt(halt),
    .busy(busy), .issue(issue), .col(col)
  );

  ddl_pair_sums #(.SW(SW), .BLK(BLK)) u_pairs (
    .clk(clk), .rst_n(rst_n), .load(accept), .nb_flat(nb_top),
    .ur_avail(ur_avail), .first_blk(first_blk), .pairs_flat(pairs)
  );

  ddl_col_gen #(.SW(SW), .BLK(BLK)) u_gen (
    .pairs_flat(pairs), .col(col), .col_pix(col_pix)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_valid <= 1'b0;
      col_idx   <= '0;
      col_data  <= '0;
    end else begin
      col_valid <= issue;
      if (issue) begin
        col_idx  <= col;
        col_data <= col_pix;
      end
    end
  end
endmodule

// File: rtl/ddl4x4_pred_chk.sv
module ddl4x4_pred_chk #(
  parameter int SW  = 8,
  parameter int BLK = 4,
  localparam int CW = $clog2(BLK)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                nb_valid,
  input logic                nb_ready,
  input logic                first_blk,
  input logic                halt,
  input logic                col_valid,
  input logic [CW-1:0]       col_idx,
  input logic [BLK*SW-1:0]   col_data
);
  logic                  zero_q;
  logic [CW-1:0]         exp_idx;
  logic [BLK*SW-1:0]     prev_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_q   <= 1'b0;
      exp_idx  <= '0;
      prev_col <= '0;
    end else begin
      if (nb_valid && nb_ready) begin
        zero_q  <= first_blk;
        exp_idx <= '0;
      end else if (col_valid) begin
        exp_idx <= exp_idx + 1'b1;
      end
      if (col_valid) prev_col <= col_data;
    end
  end

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_idx != CW'(BLK-1)) |-> !nb_ready);

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_valid && nb_ready) |=> (!nb_ready && !col_valid));

  // R7
  first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && zero_q) |-> (col_data == '0));

  // R8
  col_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> (col_idx == exp_idx));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!col_valid && $stable(col_data) && $stable(col_idx)));

  // R5
  for (genvar r = 0; r < BLK - 1; r++) begin : g_diag
    diag_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && col_idx != '0) |->
        (col_data[r*SW +: SW] == prev_col[(r+1)*SW +: SW]));
  end
endmodule

bind ddl4x4_pred ddl4x4_pred_chk #(.SW(SW), .BLK(BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .nb_valid(nb_valid), .nb_ready(nb_ready),
  .first_blk(first_blk), .halt(halt), .col_valid(col_valid),
  .col_idx(col_idx), .col_data(col_data)
);

// File: tb/ddl4x4_pred_tb.sv
module ddl4x4_pred_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nb_valid = 1'b0;
  logic        nb_ready;
  logic [63:0] nb_top = '0;
  logic        ur_avail = 1'b0;
  logic        first_blk = 1'b0;
  logic        halt = 1'b0;
  logic        col_valid;
  logic [1:0]  col_idx;
  logic [31:0] col_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4ns clk = ~clk;

  ddl4x4_pred u_dut (
    .clk(clk), .rst_n(rst_n), .nb_valid(nb_valid), .nb_ready(nb_ready),
    .nb_top(nb_top), .ur_avail(ur_avail), .first_blk(first_blk), .halt(halt),
    .col_valid(col_valid), .col_idx(col_idx), .col_data(col_data)
  );

  // vector layout: [65] first_blk, [64] ur_avail, [63:0] A..H with A low
  localparam logic [65:0] VEC [6] = '{
    {1'b0, 1'b1, 64'h0807060504030201},
    {1'b0, 1'b1, 64'hFFFFFFFFFFFFFFFF},
    {1'b0, 1'b0, 64'hAA55AA5540302010},
    {1'b1, 1'b1, 64'h123456789ABCDEF0},
    {1'b0, 1'b1, 64'hFF00FF00FF00FF00},
    {1'b0, 1'b1, 64'hFF00C0117F80E003}
  };

  function automatic logic [7:0] exp_pix(logic [65:0] v, int k);
    logic [9:0] n [9];
    for (int i = 0; i < 8; i++) begin
      n[i] = {2'b00, v[8*i +: 8]};
      if (!v[64] && i >= 4) n[i] = {2'b00, v[31:24]};
    end
    n[8] = n[7];
    if (v[65]) return 8'h00;
    return 8'((n[k] + 2*n[k+1] + n[k+2] + 10'd2) >> 2);
  endfunction

  function automatic logic [31:0] exp_col(logic [65:0] v, int j);
    logic [31:0] c;
    for (int i = 0; i < 4; i++) c[8*i +: 8] = exp_pix(v, i + j);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Sends one set, then collects four columns. halt is high for cycles
  // [h_at, h_at+h_len); poke drives a conflicting set while busy.
  task automatic run_block(input logic [65:0] v, input int h_at, input int h_len,
                           input bit poke, input string tag);
    int got = 0;
    logic [31:0] last_d;
    logic [1:0]  last_i;
    bit halted;
    @(negedge clk);
    nb_valid = 1'b1; nb_top = v[63:0]; ur_avail = v[64]; first_blk = v[65];
    @(negedge clk);
    nb_valid = 1'b0;
    // R2: accepting edge drops ready; R8: no valid yet
    chk(!nb_ready && !col_valid, {"R2 R8 accept ", tag}, {30'd0, nb_ready, col_valid}, 32'd0);
    last_d = col_data; last_i = col_idx;
    for (int cyc = 0; cyc < 40 && got < 4; cyc++) begin
      halted = (cyc >= h_at) && (cyc < h_at + h_len);
      halt = halted;
      if (poke && (cyc == 1 || cyc == 2)) begin
        nb_valid = 1'b1; nb_top = ~v[63:0]; ur_avail = ~v[64]; first_blk = ~v[65];
      end else begin
        nb_valid = 1'b0;
      end
      @(negedge clk);
      if (halted) begin
        // R9
        chk(!col_valid && col_data == last_d && col_idx == last_i,
            {"R9 halt hold ", tag}, col_data, last_d);
      end else begin
        if (cyc == 0) chk(col_valid, {"R8 first valid timing ", tag}, {31'd0, col_valid}, 32'd1);
        if (col_valid) begin
          chk(col_idx == 2'(got), {"R8 column order ", tag}, {30'd0, col_idx}, got);
          // R3 R4 R5 R6 R7 R11 and R2 (poke ignored)
          chk(col_data == exp_col(v, got), {"R3 R4 R6 R7 R11 data ", tag}, col_data, exp_col(v, got));
          if (got < 3) chk(!nb_ready, {"R2 busy ready ", tag}, {31'd0, nb_ready}, 32'd0);
          else         chk(nb_ready, {"R10 ready with last ", tag}, {31'd0, nb_ready}, 32'd1);
          got++;
        end
      end
      last_d = col_data; last_i = col_idx;
    end
    halt = 1'b0; nb_valid = 1'b0;
    chk(got == 4, {"R8 four columns ", tag}, got, 4);
    @(negedge clk);
    chk(!col_valid && nb_ready, {"R10 idle after ", tag}, {30'd0, nb_ready, col_valid}, 32'd2);
  endtask

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!col_valid && col_data == 0 && nb_ready, "R1 in reset", col_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!col_valid && col_data == 0 && nb_ready, "R1 after reset", {30'd0, nb_ready, col_valid}, 32'd2);

    for (int t = 0; t < 6; t++) run_block(VEC[t], 99, 0, 1'b0, $sformatf("vec%0d", t));

    // R4 bottom-right corner directly: G=0x00, H=0xFF -> 191
    chk(exp_pix(VEC[5], 6) == 8'd191, "R4 model corner", exp_pix(VEC[5], 6), 8'd191);

    // halt on the edge issuing column 0, then on the edge issuing column 3
    run_block(VEC[0], 0, 2, 1'b0, "halt_c0");
    run_block(VEC[4], 3, 3, 1'b0, "halt_c3");
    run_block(VEC[2], 1, 1, 1'b0, "halt_mid");
    // R2: new set offered while busy has no effect
    run_block(VEC[5], 99, 0, 1'b1, "poke");
    // R7 then normal: zero flag does not stick
    run_block(VEC[3], 99, 0, 1'b0, "first");
    run_block(VEC[1], 99, 0, 1'b0, "after_first");

    // R10: idle block stays silent with no offer
    repeat (3) begin
      @(negedge clk);
      chk(!col_valid && nb_ready, "R10 quiet idle", {30'd0, nb_ready, col_valid}, 32'd2);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule